// File: doc/BRIEF.md
# Subcode Asynchronous Byte Serializer

This block turns a stream of 7-bit subcode symbols (channels Q through W) into a single-wire, start-bit framed serial line. A producer offers one symbol at a time over a valid/ready handshake and marks the first symbol of each subcode block with a block flag. The serializer announces each block with a long low pause, then sends every symbol as a high start bit followed by the seven channel bits, Q first and W last. It leaves the line low between bytes for a bounded gap.

Every duration is counted in system clock cycles. Parameters give the bit time, the block pause and the gap limits for single speed. The speed selector `speed_sel` holds n-1 for a speed factor n from 1 to 4, and each duration is divided by n (integer division, never below one cycle). Below, B, P, Gmin and Gmax are the scaled bit time, pause, minimum gap and maximum gap. The speed is captured only when a block starts from idle, so a speed change never alters a block in flight. The line is low whenever no bit is being sent. If the producer leaves a gap open until Gmax runs out, the block is abandoned with a one-cycle underrun pulse.

Top module: `subq_async_ser`

## Requirements
- R1: During and right after reset, `ser_out` is 0, `sym_ready` is 1 and `underrun` is 0.
- R2: When a symbol with `sym_block`=1 is accepted in idle, `ser_out` stays 0 for exactly P cycles after the accepting clock edge, and then the byte begins.
- R3: A byte is 8 bit slots of B cycles each: a start slot of 1, then the symbol bits in the order `sym_data[6]` (Q) down to `sym_data[0]` (W).
- R4: After a byte that is not the last of the block, the line is low for at least Gmin cycles. If a symbol is already waiting, the next start bit follows exactly Gmin low cycles after the previous byte.
- R5: `sym_ready` is 0 during the block pause, during a byte, and for the first Gmin-1 cycles of a gap. It rises in the last cycle of the minimum gap.
- R6: If a gap reaches Gmax low cycles with no symbol accepted, `underrun` is 1 for exactly the next cycle and the serializer returns to idle.
- R7: In idle, a symbol with `sym_block`=0 is consumed and dropped. `ser_out` stays 0 and `sym_ready` stays 1.
- R8: A block holds 96 bytes. After the 96th byte the serializer returns to idle at once: `sym_ready` rises in the first cycle after the last bit, and no underrun is raised.
- R9: `speed_sel` is sampled only when a block-start symbol is accepted in idle. Changing it later in the block does not change B, Gmin, Gmax or P.
- R10: A block-start symbol accepted during a gap restarts the block. The line stays low for P more cycles, that symbol is sent next, and the byte count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_sel | input | 2 | Speed factor minus one (0..3 for n = 1..4) |
| sym_valid | input | 1 | A symbol is offered |
| sym_data | input | 7 | Subcode symbol, bit 6 = Q ... bit 0 = W |
| sym_block | input | 1 | Offered symbol is the first of a subcode block |
| sym_ready | output | 1 | Symbol is taken at this clock edge when valid |
| ser_out | output | 1 | Serial line, idle low |
| underrun | output | 1 | One-cycle pulse: gap limit expired, block dropped |

## Verification
Each result is due at a fixed number of cycles after the edge that accepts a symbol. The pause fills the P cycles right after acceptance. Bit slot i covers cycles P+iB+1 through P+(i+1)B. The next start bit comes exactly Gmin cycles after the last slot, and the underrun pulse comes Gmax+1 cycles after it. The bench records the line, the ready signal and the underrun flag on every falling edge into a ring indexed by cycle number. It then compares each recorded cycle against offsets computed from the scaled parameters, relative to the cycle of acceptance. Two more checks confirm the timing: it compares the cycle in which the second symbol is taken against its computed value, and it selects a different speed mid-block to show that the offsets do not move.

// File: rtl/subq_ser_pkg.sv
package subq_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PAUSE = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } ser_state_e;

    // Duration at speed factor n, never shorter than one cycle.
    function automatic int scaled(input int base, input int n);
        int q;
        q = base / n;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/subq_rate_tbl.sv
module subq_rate_tbl #(
    parameter int SPD_W        = 2,
    parameter int CNT_W        = 9,
    parameter int BIT_CYC1     = 24,
    parameter int PAUSE_CYC1   = 432,
    parameter int GAP_MIN_CYC1 = 24,
    parameter int GAP_MAX_CYC1 = 192
) (
    input  logic [SPD_W-1:0] spd,
    output logic [CNT_W-1:0] bit_len,
    output logic [CNT_W-1:0] pause_len,
    output logic [CNT_W-1:0] gmin_len,
    output logic [CNT_W-1:0] gmax_len
);
    localparam int N_SPEEDS = 1 << SPD_W;

    logic [CNT_W-1:0] bit_tab   [N_SPEEDS];
    logic [CNT_W-1:0] pause_tab [N_SPEEDS];
    logic [CNT_W-1:0] gmin_tab  [N_SPEEDS];
    logic [CNT_W-1:0] gmax_tab  [N_SPEEDS];

    for (genvar g = 0; g < N_SPEEDS; g++) begin : g_spd
        localparam int BL = subq_ser_pkg::scaled(BIT_CYC1, g + 1);
        localparam int PL = subq_ser_pkg::scaled(PAUSE_CYC1, g + 1);
        localparam int NL = subq_ser_pkg::scaled(GAP_MIN_CYC1, g + 1);
        localparam int XL = subq_ser_pkg::scaled(GAP_MAX_CYC1, g + 1);
        assign bit_tab[g]   = CNT_W'(BL);
        assign pause_tab[g] = CNT_W'(PL);
        assign gmin_tab[g]  = CNT_W'(NL);
        assign gmax_tab[g]  = CNT_W'(XL);
    end

    assign bit_len   = bit_tab[spd];
    assign pause_len = pause_tab[spd];
    assign gmin_len  = gmin_tab[spd];
    assign gmax_len  = gmax_tab[spd];

endmodule

// File: rtl/subq_bit_shifter.sv
module subq_bit_shifter #(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   bit_len,
    output logic               line,
    output logic               last
);
    localparam int IDX_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   tick;
        logic               active;
    } sh_t;

    sh_t sh_d, sh_q;
    logic slot_end;

    always_comb begin
        sh_d     = sh_q;
        slot_end = sh_q.active && (sh_q.tick == bit_len - CNT_W'(1));
        last     = slot_end && (sh_q.idx == IDX_W'(FRAME_W - 1));
        if (load) begin
            sh_d.sreg   = load_frame;
            sh_d.idx    = '0;
            sh_d.tick   = '0;
            sh_d.active = 1'b1;
        end else if (sh_q.active) begin
            if (slot_end) begin
                sh_d.tick = '0;
                if (last) begin
                    sh_d.active = 1'b0;
                end else begin
                    sh_d.idx  = sh_q.idx + IDX_W'(1);
                    sh_d.sreg = {sh_q.sreg[FRAME_W-2:0], 1'b0};
                end
            end else begin
                sh_d.tick = sh_q.tick + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign line = sh_q.active & sh_q.sreg[FRAME_W-1];

    logic act_q;
    logic [CNT_W-1:0] tick_q;
    assign act_q  = sh_q.active;
    assign tick_q = sh_q.tick;

    // R3: a bit slot holds its level for the whole bit time
    p_slot_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && tick_q != '0) |-> $stable(line))
        else $error("bit level changed inside a slot");

    // R3: the line drops to idle once the last slot is over
    p_quiet_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !line)
        else $error("line not idle after last slot");

endmodule

// File: rtl/subq_async_ser.sv
module subq_async_ser #(
    parameter int SYM_W        = 7,
    parameter int SPD_W        = 2,
    parameter int BLOCK_BYTES  = 96,
    parameter int BIT_CYC1     = 24,
    parameter int PAUSE_CYC1   = 432,
    parameter int GAP_MIN_CYC1 = 24,
    parameter int GAP_MAX_CYC1 = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed_sel,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             sym_block,
    output logic             sym_ready,
    output logic             ser_out,
    output logic             underrun
);
    import subq_ser_pkg::*;

    localparam int FRAME_W = SYM_W + 1;
    localparam int CNT_MAX = imax(imax(PAUSE_CYC1, GAP_MAX_CYC1), imax(BIT_CYC1, GAP_MIN_CYC1));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BYTE_W  = $clog2(BLOCK_BYTES + 1);

    typedef struct packed {
        ser_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] bytes;
        logic [SPD_W-1:0]  spd;
        logic [SYM_W-1:0]  sym;
        logic              und;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]   bit_len, pause_len, gmin_len, gmax_len;
    logic               sh_load, sh_last, sh_line;
    logic [FRAME_W-1:0] sh_frame;

    subq_rate_tbl #(
        .SPD_W       (SPD_W),
        .CNT_W       (CNT_W),
        .BIT_CYC1    (BIT_CYC1),
        .PAUSE_CYC1  (PAUSE_CYC1),
        .GAP_MIN_CYC1(GAP_MIN_CYC1),
        .GAP_MAX_CYC1(GAP_MAX_CYC1)
    ) u_rate (
        .spd      (ctl_q.spd),
        .bit_len  (bit_len),
        .pause_len(pause_len),
        .gmin_len (gmin_len),
        .gmax_len (gmax_len)
    );

    subq_bit_shifter #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_frame(sh_frame),
        .bit_len   (bit_len),
        .line      (sh_line),
        .last      (sh_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.und = 1'b0;
        sh_load   = 1'b0;
        sh_frame  = {1'b1, ctl_q.sym};
        sym_ready = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                sym_ready = 1'b1;
                if (sym_valid && sym_block) begin
                    ctl_d.sym   = sym_data;
                    ctl_d.spd   = speed_sel;
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (ctl_q.cnt == pause_len - CNT_W'(1)) begin
                    sh_load     = 1'b1;
                    ctl_d.bytes = BYTE_W'(1);
                    ctl_d.state = ST_SHIFT;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (sh_last) begin
                    ctl_d.cnt   = '0;
                    ctl_d.state = (ctl_q.bytes == BYTE_W'(BLOCK_BYTES)) ? ST_IDLE : ST_GAP;
                end
            end
            ST_GAP: begin
                sym_ready = (ctl_q.cnt >= gmin_len - CNT_W'(1));
                if (sym_ready && sym_valid) begin
                    if (sym_block) begin
                        ctl_d.sym   = sym_data;
                        ctl_d.cnt   = '0;
                        ctl_d.bytes = '0;
                        ctl_d.state = ST_PAUSE;
                    end else begin
                        sh_load     = 1'b1;
                        sh_frame    = {1'b1, sym_data};
                        ctl_d.bytes = ctl_q.bytes + BYTE_W'(1);
                        ctl_d.state = ST_SHIFT;
                    end
                end else if (ctl_q.cnt >= gmax_len - CNT_W'(1)) begin
                    ctl_d.und   = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ser_out  = sh_line;
    assign underrun = ctl_q.und;

    ser_state_e st_q;
    assign st_q = ctl_q.state;

    // R2, R4: the line is low everywhere outside a byte
    p_quiet_outside_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_SHIFT) |-> !ser_out)
        else $error("line high outside a byte");

    // R3: a loaded byte opens with its start bit
    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |=> ser_out)
        else $error("missing start bit");

    // R6: underrun is only seen once back in idle with the line low
    p_underrun_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (st_q == ST_IDLE && !ser_out && sym_ready))
        else $error("underrun outside idle");

    // R6: underrun never lasts two cycles
    p_underrun_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun)
        else $error("underrun longer than one cycle");

    // R8: the byte count never passes the block size
    p_byte_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.bytes <= BYTE_W'(BLOCK_BYTES))
        else $error("byte count past block size");

endmodule

// File: tb/subq_async_ser_tb.sv
module subq_async_ser_tb;

    localparam int BIT1   = 24;
    localparam int PAUSE1 = 432;
    localparam int GMIN1  = 24;
    localparam int GMAX1  = 192;
    localparam int RING   = 2048;

    // {speed[1:0], first symbol[6:0], second symbol[6:0], second is block start}
    localparam logic [16:0] VEC [6] = '{
        {2'd0, 7'h55, 7'h2A, 1'b0},
        {2'd1, 7'h7F, 7'h01, 1'b0},
        {2'd2, 7'h40, 7'h3C, 1'b1},
        {2'd3, 7'h00, 7'h7F, 1'b0},
        {2'd3, 7'h1B, 7'h64, 1'b1},
        {2'd0, 7'h01, 7'h40, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_sel = '0;
    logic       sym_valid = 1'b0;
    logic [6:0] sym_data = '0;
    logic       sym_block = 1'b0;
    logic       sym_ready, ser_out, underrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic tr_line [RING];
    logic tr_rdy  [RING];
    logic tr_und  [RING];

    subq_async_ser u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_sel(speed_sel),
        .sym_valid(sym_valid),
        .sym_data (sym_data),
        .sym_block(sym_block),
        .sym_ready(sym_ready),
        .ser_out  (ser_out),
        .underrun (underrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tr_line[cyc % RING] = ser_out;
        tr_rdy[cyc % RING]  = sym_ready;
        tr_und[cyc % RING]  = underrun;
    end

    function automatic int blen(input int sp);  return BIT1 / (sp + 1);   endfunction
    function automatic int plen(input int sp);  return PAUSE1 / (sp + 1); endfunction
    function automatic int gnlen(input int sp); return GMIN1 / (sp + 1);  endfunction
    function automatic int gxlen(input int sp); return GMAX1 / (sp + 1);  endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Checks that a traced signal holds one value over a run of cycles.
    task automatic check_run(input string tag, input int which, input int from,
                             input int len, input logic val);
        int bad_at = -1;
        logic got = val;
        for (int i = 0; i < len; i++) begin
            logic s;
            s = (which == 0) ? tr_line[(from + i) % RING] :
                (which == 1) ? tr_rdy[(from + i) % RING] : tr_und[(from + i) % RING];
            if (s !== val && bad_at < 0) begin
                bad_at = i;
                got = s;
            end
        end
        n_chk++;
        if (bad_at >= 0) begin
            n_bad++;
            $display("FAIL %s at offset %0d: actual=%0b expected=%0b", tag, bad_at, got, val);
        end
    endtask

    // Checks one byte frame on the traced line: start 1, then Q..W.
    task automatic check_byte(input string tag, input int from, input logic [6:0] d, input int b);
        logic [7:0] frame;
        int bad_at = -1;
        logic got = 1'b0;
        logic want = 1'b0;
        frame = {1'b1, d};
        for (int i = 0; i < 8 * b; i++) begin
            logic e;
            e = frame[7 - i / b];
            if (tr_line[(from + i) % RING] !== e && bad_at < 0) begin
                bad_at = i;
                got = tr_line[(from + i) % RING];
                want = e;
            end
        end
        n_chk++;
        if (bad_at >= 0) begin
            n_bad++;
            $display("FAIL %s byte %0h at cycle %0d: actual=%0b expected=%0b", tag, d, bad_at, got, want);
        end
    endtask

    task automatic wait_idx(input int idx);
        while (cyc <= idx) @(negedge clk);
    endtask

    // Called at a falling edge; returns the cycle index of the first
    // falling edge after the accepting rising edge.
    task automatic send(input logic [6:0] d, input logic blk, input logic [1:0] sp, output int acc);
        sym_data  = d;
        sym_block = blk;
        speed_sel = sp;
        sym_valid = 1'b1;
        while (!sym_ready) @(negedge clk);
        @(negedge clk);
        acc = cyc;
        sym_valid = 1'b0;
        sym_block = 1'b0;
    endtask

    task automatic do_reset();
        sym_valid = 1'b0;
        sym_block = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, st2, e2, last_acc;
        logic [1:0] sp;
        logic [6:0] d1, d2;
        logic       blk2;
        int bl, pl, gn, gx;

        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 line in reset", ser_out, 1'b0);
        check("R1 underrun in reset", underrun, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line after reset", ser_out, 1'b0);
        check("R1 ready after reset", sym_ready, 1'b1);
        check("R1 underrun after reset", underrun, 1'b0);

        // Vector walk: R2 R3 R4 R5 R6 R9 R10
        foreach (VEC[v]) begin
            {sp, d1, d2, blk2} = VEC[v];
            bl = blen(sp); pl = plen(sp); gn = gnlen(sp); gx = gxlen(sp);
            do_reset();
            send(d1, 1'b1, sp, a);
            send(d2, blk2, ~sp, b);   // R9: speed input changed mid-block
            check("R4 R9 second symbol accept cycle", b, a + pl + 8 * bl + gn);
            st2 = blk2 ? b + pl : b;
            e2  = st2 + 8 * bl;
            wait_idx(e2 + gx + 2);
            check_run("R2 block pause low", 0, a, pl, 1'b0);
            check_byte("R3 first byte", a + pl, d1, bl);
            check_run("R4 min gap low", 0, a + pl + 8 * bl, gn, 1'b0);
            check_run("R5 ready low in pause and byte", 1, a, pl + 8 * bl, 1'b0);
            check_run("R5 ready low early gap", 1, a + pl + 8 * bl, gn - 1, 1'b0);
            check("R5 ready at gap floor", tr_rdy[(b - 1) % RING], 1'b1);
            if (blk2) check_run("R10 restart pause low", 0, b, pl, 1'b0);
            check_byte("R3 R9 R10 second byte", st2, d2, bl);
            check_run("R6 gap low until limit", 0, e2, gx, 1'b0);
            check("R6 no early underrun", tr_und[(e2 + gx - 1) % RING], 1'b0);
            check("R6 underrun pulse", tr_und[(e2 + gx) % RING], 1'b1);
            check("R6 underrun one cycle", tr_und[(e2 + gx + 1) % RING], 1'b0);
            check("R6 ready after underrun", tr_rdy[(e2 + gx) % RING], 1'b1);
        end

        // R6 R7: after underrun, a non-block symbol is dropped
        send(7'h7F, 1'b0, 2'd3, a);
        wait_idx(a + 600);
        check_run("R6 R7 dropped symbol line low", 0, a, 600, 1'b0);
        check_run("R7 ready stays high", 1, a, 600, 1'b1);

        // R7: after reset, a non-block symbol is dropped
        do_reset();
        send(7'h55, 1'b0, 2'd0, a);
        wait_idx(a + 600);
        check_run("R7 idle drop line low", 0, a, 600, 1'b0);
        check_run("R7 idle drop ready high", 1, a, 600, 1'b1);

        // R8: a full block of 96 bytes at speed 4
        do_reset();
        bl = blen(3); gx = gxlen(3);
        send(7'h00, 1'b1, 2'd3, a);
        last_acc = a;
        for (int i = 1; i < 96; i++) send(7'(i), 1'b0, 2'd3, last_acc);
        wait_idx(last_acc + 8 * bl + gx + 10);
        check_byte("R8 last byte", last_acc, 7'(95), bl);
        check("R8 ready low in last slot", tr_rdy[(last_acc + 8 * bl - 1) % RING], 1'b0);
        check("R8 idle right after block", tr_rdy[(last_acc + 8 * bl) % RING], 1'b1);
        check_run("R8 no underrun after block", 2, last_acc, 8 * bl + gx + 10, 1'b0);
        check_run("R8 line low after block", 0, last_acc + 8 * bl, gx + 10, 1'b0);

        // R2: a new block from idle after a full block
        send(7'h2A, 1'b1, 2'd1, a);
        wait_idx(a + plen(1) + 8 * blen(1) + 2);
        check_run("R2 new block pause", 0, a, plen(1), 1'b0);
        check_byte("R2 R3 new block byte", a + plen(1), 7'h2A, blen(1));

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule